// File: doc/BRIEF.md
# Registered AHB Bridge with Posted Write

This block joins two AHB-Lite buses that run on the same clock. The upstream port faces a bus master and acts as a slave. The downstream port acts as a master toward the next bus. Every signal driven onto the downstream bus comes from a flop, so no timing path runs from one bus to the other. The two sides share the data width and clock, and the bridge holds at most one transfer in flight downstream.

A single-entry write buffer holds one address, one size and one data word. If the buffer is empty when a write reaches its data phase, the write completes upstream with no wait states, and the bridge replays it downstream later. Reads stall the upstream master until the downstream data phase ends. Any buffered write goes out first, so a read always sees the data written before it. A downstream error on a read reaches the master as the usual two-cycle error response. The master has already been told that a posted write succeeded, so a downstream error on that write can only set a sticky flag.

Top module: `ahb_post_bridge`

## Requirements
- R1: Once reset is released, the buffer is empty, `m_htrans` reads IDLE (2'b00), `s_hreadyout` is 1, `s_hresp` is 0 and `wr_err_flag` is 0.
- R2: An upstream write whose data phase finds the buffer empty completes with zero wait states and an OKAY response.
- R3: Each accepted upstream NONSEQ or SEQ transfer (`s_htrans[1]`=1) produces exactly one downstream NONSEQ transfer. A buffered write is replayed with its own address, size and data.
- R4: An upstream write whose data phase finds the buffer occupied is stalled until the buffer drains. With back-to-back writes and W downstream wait states, the second write sees 3+W wait cycles.
- R5: A read issued while a write is buffered goes downstream only after that write completes, and it returns the data just written. When the read's address phase directly follows a zero-wait write's data phase, the read sees 5+2W wait cycles.
- R6: A read that finds the buffer empty and the downstream bus idle sees 3+W wait cycles. The read data is on `s_hrdata` in the first cycle with `s_hreadyout` high.
- R7: A downstream ERROR on a read reaches the master as one cycle with `s_hresp`=1 and `s_hreadyout`=0, then one cycle with `s_hresp`=1 and `s_hreadyout`=1. This gives 5+W wait cycles when the read starts with the buffer empty.
- R8: A downstream ERROR on a buffered write does not change the upstream response, which is still OKAY with zero wait. It sets `wr_err_flag`, which stays high until reset. Read errors leave `wr_err_flag` unchanged.
- R9: Upstream IDLE (2'b00) or BUSY (2'b01) transfers, and transfers with `s_hsel` low, get an OKAY response with zero wait states and start no downstream transfer.
- R10: `m_htrans` carries only IDLE or NONSEQ (2'b10). NONSEQ lasts one cycle when `m_hready` is high and is held, with a stable address, while `m_hready` is low. An upstream NONSEQ does not change `m_htrans` in the same cycle or in the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both buses |
| rst | input | 1 | Synchronous active-high reset |
| s_hsel | input | 1 | Upstream slave select |
| s_haddr | input | ADDR_W | Upstream address |
| s_htrans | input | 2 | Upstream transfer type |
| s_hwrite | input | 1 | Upstream write (1) or read (0) |
| s_hsize | input | 3 | Upstream transfer size |
| s_hwdata | input | DATA_W | Upstream write data |
| s_hready | input | 1 | Upstream bus ready |
| s_hreadyout | output | 1 | Ready driven by the bridge upstream |
| s_hresp | output | 1 | Upstream response, 1 = ERROR |
| s_hrdata | output | DATA_W | Upstream read data |
| m_haddr | output | ADDR_W | Downstream address, registered |
| m_htrans | output | 2 | Downstream transfer type, registered |
| m_hwrite | output | 1 | Downstream write flag, registered |
| m_hsize | output | 3 | Downstream size, registered |
| m_hwdata | output | DATA_W | Downstream write data, registered |
| m_hready | input | 1 | Downstream bus ready |
| m_hresp | input | 1 | Downstream response, 1 = ERROR |
| m_hrdata | input | DATA_W | Downstream read data |
| wr_err_flag | output | 1 | Sticky flag for an error on a posted write |

## Verification
The bench builds the bridge with ADDR_W=8 and DATA_W=16. It attaches a downstream slave model with sixteen halfword locations, one of which always answers ERROR. The slave's wait-state count W runs from 0 to 3. At each W the bench writes and reads back every non-error location, so the wait counts, which depend on W, are checked against the formulas in the requirements at every W. The small address space lets the bench cover every location under every wait-state setting.

// File: rtl/hpb_pkg.sv
`timescale 1ns/1ps
package hpb_pkg;

    localparam int HTRANS_W = 2;
    localparam int HSIZE_W  = 3;

    typedef enum logic [HTRANS_W-1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    // Upstream data-phase tracker
    typedef enum logic [2:0] {
        UP_IDLE,
        UP_WR,
        UP_RD,
        UP_RDOK,
        UP_ERR1,
        UP_ERR2
    } up_state_e;

    // Downstream sequencer
    typedef enum logic [1:0] {
        DN_IDLE,
        DN_ADDR,
        DN_DATA
    } dn_state_e;

    // NONSEQ and SEQ request a transfer; IDLE and BUSY do not.
    function automatic logic is_active(input logic [HTRANS_W-1:0] tr);
        return tr[1];
    endfunction

endpackage

// File: rtl/hpb_up_ctrl.sv
`timescale 1ns/1ps
module hpb_up_ctrl
    import hpb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                s_hsel,
    input  logic [AW-1:0]       s_haddr,
    input  logic [HTRANS_W-1:0] s_htrans,
    input  logic                s_hwrite,
    input  logic [HSIZE_W-1:0]  s_hsize,
    input  logic                s_hready,
    input  logic                wb_valid,
    input  logic                rd_take,
    input  logic                rd_done,
    input  logic                rd_err,
    output logic                s_hreadyout,
    output logic                s_hresp,
    output logic                wb_fill,
    output logic [AW-1:0]       wr_addr,
    output logic [HSIZE_W-1:0]  wr_size,
    output logic                rd_req,
    output logic [AW-1:0]       rd_addr,
    output logic [HSIZE_W-1:0]  rd_size
);

    up_state_e state_q, state_d;
    logic      accept;
    logic      phase_done;

    assign accept = s_hsel && is_active(s_htrans) && s_hready;

    always_comb begin
        unique case (state_q)
            UP_WR:          s_hreadyout = !wb_valid;
            UP_RD, UP_ERR1: s_hreadyout = 1'b0;
            default:        s_hreadyout = 1'b1;
        endcase
    end

    assign s_hresp    = (state_q == UP_ERR1) || (state_q == UP_ERR2);
    assign wb_fill    = (state_q == UP_WR) && !wb_valid;
    assign phase_done = s_hreadyout && s_hready;

    always_comb begin
        state_d = state_q;
        case (state_q)
            UP_RD:   if (rd_done) state_d = rd_err ? UP_ERR1 : UP_RDOK;
            UP_ERR1: state_d = UP_ERR2;
            default: if (phase_done) state_d = accept ? (s_hwrite ? UP_WR : UP_RD) : UP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UP_IDLE;
            rd_req  <= 1'b0;
            wr_addr <= '0;
            wr_size <= '0;
            rd_addr <= '0;
            rd_size <= '0;
        end else begin
            state_q <= state_d;
            if (accept && phase_done) begin
                if (s_hwrite) begin
                    wr_addr <= s_haddr;
                    wr_size <= s_hsize;
                end else begin
                    rd_addr <= s_haddr;
                    rd_size <= s_hsize;
                    rd_req  <= 1'b1;
                end
            end
            if (rd_take) rd_req <= 1'b0;
        end
    end

    AST_WR_ZERO_WAIT: assert property (@(posedge clk) disable iff (rst) (accept && phase_done && s_hwrite && !wb_valid && !wb_fill) |=> s_hreadyout); // R2
    AST_RD_STALLS: assert property (@(posedge clk) disable iff (rst) (accept && phase_done && !s_hwrite) |=> !s_hreadyout); // R6
    AST_ERR_SECOND: assert property (@(posedge clk) disable iff (rst) (s_hresp && !s_hreadyout) |=> (s_hresp && s_hreadyout)); // R7
    AST_ERR_OPENS_LOW: assert property (@(posedge clk) disable iff (rst) $rose(s_hresp) |-> !s_hreadyout); // R7

endmodule

// File: rtl/hpb_wbuf.sv
`timescale 1ns/1ps
module hpb_wbuf
    import hpb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fill,
    input  logic [AW-1:0]      fill_addr,
    input  logic [HSIZE_W-1:0] fill_size,
    input  logic [DW-1:0]      fill_data,
    input  logic               drain,
    output logic               valid,
    output logic [AW-1:0]      addr,
    output logic [HSIZE_W-1:0] size,
    output logic [DW-1:0]      data
);

    typedef struct packed {
        logic [AW-1:0]      addr;
        logic [HSIZE_W-1:0] size;
        logic [DW-1:0]      data;
    } entry_t;

    entry_t entry_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            entry_q <= '0;
        end else if (fill) begin
            valid   <= 1'b1;
            entry_q <= '{addr: fill_addr, size: fill_size, data: fill_data};
        end else if (drain) begin
            valid   <= 1'b0;
        end
    end

    assign addr = entry_q.addr;
    assign size = entry_q.size;
    assign data = entry_q.data;

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst) fill |-> !valid); // R4
    AST_DRAIN_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst) drain |-> valid); // R3

endmodule

// File: rtl/hpb_dn_seq.sv
`timescale 1ns/1ps
module hpb_dn_seq
    import hpb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wb_valid,
    input  logic [AW-1:0]       wb_addr,
    input  logic [HSIZE_W-1:0]  wb_size,
    input  logic [DW-1:0]       wb_data,
    input  logic                rd_req,
    input  logic [AW-1:0]       rd_addr,
    input  logic [HSIZE_W-1:0]  rd_size,
    input  logic                m_hready,
    input  logic                m_hresp,
    input  logic [DW-1:0]       m_hrdata,
    output logic [AW-1:0]       m_haddr,
    output logic [HTRANS_W-1:0] m_htrans,
    output logic                m_hwrite,
    output logic [HSIZE_W-1:0]  m_hsize,
    output logic [DW-1:0]       m_hwdata,
    output logic                wb_drain,
    output logic                rd_take,
    output logic                rd_done,
    output logic                rd_err,
    output logic [DW-1:0]       rd_data,
    output logic                wr_err
);

    dn_state_e state_q;
    logic      launch_wr, launch_rd, complete;

    // A buffered write always wins, which keeps write-then-read order.
    assign launch_wr = (state_q == DN_IDLE) && wb_valid;
    assign launch_rd = (state_q == DN_IDLE) && !wb_valid && rd_req;
    assign complete  = (state_q == DN_DATA) && m_hready;

    assign rd_take  = launch_rd;
    assign wb_drain = complete && m_hwrite;
    assign rd_done  = complete && !m_hwrite;
    assign rd_err   = m_hresp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= DN_IDLE;
            m_htrans <= TR_IDLE;
            m_haddr  <= '0;
            m_hwrite <= 1'b0;
            m_hsize  <= '0;
            m_hwdata <= '0;
            rd_data  <= '0;
            wr_err   <= 1'b0;
        end else begin
            case (state_q)
                DN_IDLE: begin
                    if (launch_wr) begin
                        m_haddr  <= wb_addr;
                        m_hsize  <= wb_size;
                        m_hwrite <= 1'b1;
                        m_hwdata <= wb_data;
                        m_htrans <= TR_NONSEQ;
                        state_q  <= DN_ADDR;
                    end else if (launch_rd) begin
                        m_haddr  <= rd_addr;
                        m_hsize  <= rd_size;
                        m_hwrite <= 1'b0;
                        m_htrans <= TR_NONSEQ;
                        state_q  <= DN_ADDR;
                    end
                end
                DN_ADDR: begin
                    if (m_hready) begin
                        m_htrans <= TR_IDLE;
                        state_q  <= DN_DATA;
                    end
                end
                DN_DATA: begin
                    if (m_hready) begin
                        state_q <= DN_IDLE;
                        if (!m_hwrite) rd_data <= m_hrdata;
                        else if (m_hresp) wr_err <= 1'b1;
                    end
                end
                default: state_q <= DN_IDLE;
            endcase
        end
    end

    AST_TRANS_LEGAL: assert property (@(posedge clk) disable iff (rst) (m_htrans == TR_IDLE || m_htrans == TR_NONSEQ)); // R10
    AST_NONSEQ_ONCE: assert property (@(posedge clk) disable iff (rst) (m_htrans == TR_NONSEQ && m_hready) |=> (m_htrans == TR_IDLE)); // R10
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) (m_htrans == TR_NONSEQ && !m_hready) |=> (m_htrans == TR_NONSEQ && $stable(m_haddr))); // R10
    AST_RD_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst) (m_htrans == TR_NONSEQ && !m_hwrite) |-> !wb_valid); // R5

endmodule

// File: rtl/ahb_post_bridge.sv
`timescale 1ns/1ps
module ahb_post_bridge
    import hpb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                s_hsel,
    input  logic [ADDR_W-1:0]   s_haddr,
    input  logic [HTRANS_W-1:0] s_htrans,
    input  logic                s_hwrite,
    input  logic [HSIZE_W-1:0]  s_hsize,
    input  logic [DATA_W-1:0]   s_hwdata,
    input  logic                s_hready,
    output logic                s_hreadyout,
    output logic                s_hresp,
    output logic [DATA_W-1:0]   s_hrdata,
    output logic [ADDR_W-1:0]   m_haddr,
    output logic [HTRANS_W-1:0] m_htrans,
    output logic                m_hwrite,
    output logic [HSIZE_W-1:0]  m_hsize,
    output logic [DATA_W-1:0]   m_hwdata,
    input  logic                m_hready,
    input  logic                m_hresp,
    input  logic [DATA_W-1:0]   m_hrdata,
    output logic                wr_err_flag
);

    logic               wb_fill, wb_drain, wb_valid;
    logic [ADDR_W-1:0]  wr_addr, wb_addr, rd_addr;
    logic [HSIZE_W-1:0] wr_size, wb_size, rd_size;
    logic [DATA_W-1:0]  wb_data;
    logic               rd_req, rd_take, rd_done, rd_err;

    hpb_up_ctrl #(.AW(ADDR_W)) up_i (
        .clk(clk), .rst(rst),
        .s_hsel(s_hsel), .s_haddr(s_haddr), .s_htrans(s_htrans),
        .s_hwrite(s_hwrite), .s_hsize(s_hsize), .s_hready(s_hready),
        .wb_valid(wb_valid), .rd_take(rd_take), .rd_done(rd_done), .rd_err(rd_err),
        .s_hreadyout(s_hreadyout), .s_hresp(s_hresp),
        .wb_fill(wb_fill), .wr_addr(wr_addr), .wr_size(wr_size),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size)
    );

    hpb_wbuf #(.AW(ADDR_W), .DW(DATA_W)) wbuf_i (
        .clk(clk), .rst(rst),
        .fill(wb_fill), .fill_addr(wr_addr), .fill_size(wr_size), .fill_data(s_hwdata),
        .drain(wb_drain),
        .valid(wb_valid), .addr(wb_addr), .size(wb_size), .data(wb_data)
    );

    hpb_dn_seq #(.AW(ADDR_W), .DW(DATA_W)) dn_i (
        .clk(clk), .rst(rst),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_size(wb_size), .wb_data(wb_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .m_hready(m_hready), .m_hresp(m_hresp), .m_hrdata(m_hrdata),
        .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite),
        .m_hsize(m_hsize), .m_hwdata(m_hwdata),
        .wb_drain(wb_drain), .rd_take(rd_take), .rd_done(rd_done), .rd_err(rd_err),
        .rd_data(s_hrdata), .wr_err(wr_err_flag)
    );

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (m_htrans == TR_IDLE && s_hreadyout && !s_hresp && !wr_err_flag)); // R1

endmodule

// File: tb/ahb_post_bridge_tb.sv
`timescale 1ns/1ps
module ahb_post_bridge_tb_top;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int ERR_IDX = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          s_hsel = 1'b0;
    logic [AW-1:0] s_haddr = '0;
    logic [1:0]    s_htrans = 2'b00;
    logic          s_hwrite = 1'b0;
    logic [2:0]    s_hsize = 3'd1;
    logic [DW-1:0] s_hwdata = '0;
    logic          s_hready;
    logic          s_hreadyout, s_hresp;
    logic [DW-1:0] s_hrdata;
    logic [AW-1:0] m_haddr;
    logic [1:0]    m_htrans;
    logic          m_hwrite;
    logic [2:0]    m_hsize;
    logic [DW-1:0] m_hwdata;
    logic          m_hready, m_hresp;
    logic [DW-1:0] m_hrdata;
    logic          wr_err_flag;

    int checks = 0;
    int errors = 0;
    int exp_dn = 0;
    int wait_cfg = 0;
    logic [DW-1:0] exp_mem [16];

    always #10 clk = ~clk;
    assign s_hready = s_hreadyout;

    ahb_post_bridge #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .s_hsel(s_hsel), .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite),
        .s_hsize(s_hsize), .s_hwdata(s_hwdata), .s_hready(s_hready),
        .s_hreadyout(s_hreadyout), .s_hresp(s_hresp), .s_hrdata(s_hrdata),
        .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hsize(m_hsize),
        .m_hwdata(m_hwdata), .m_hready(m_hready), .m_hresp(m_hresp), .m_hrdata(m_hrdata),
        .wr_err_flag(wr_err_flag)
    );

    // Downstream slave model: W wait states, index 15 answers ERROR.
    logic [DW-1:0] mem [16];
    logic          dphase = 1'b0;
    logic          d_wr = 1'b0;
    logic [3:0]    d_idx = '0;
    int            wcnt = 0;
    int            dn_count = 0;
    logic          d_errsel;

    assign d_errsel = dphase && (d_idx == 4'(ERR_IDX));
    assign m_hready = !dphase || (d_errsel ? (wcnt == wait_cfg + 1) : (wcnt == wait_cfg));
    assign m_hresp  = d_errsel && (wcnt >= wait_cfg);
    assign m_hrdata = (dphase && !d_wr) ? mem[d_idx] : '0;

    always @(posedge clk) begin
        if (rst) begin
            dphase   <= 1'b0;
            wcnt     <= 0;
            dn_count <= 0;
        end else if (m_hready) begin
            if (dphase && d_wr && !d_errsel) mem[d_idx] <= m_hwdata;
            dphase <= m_htrans[1];
            d_wr   <= m_hwrite;
            d_idx  <= m_haddr[4:1];
            wcnt   <= 0;
            if (m_htrans[1]) dn_count <= dn_count + 1;
        end else begin
            wcnt <= wcnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int waits, output logic [DW-1:0] rdat,
                        output logic err, output logic err_pre);
        @(negedge clk);
        s_hsel = 1'b1; s_htrans = 2'b10; s_hwrite = wr; s_haddr = a; s_hsize = 3'd1;
        @(negedge clk);
        s_hsel = 1'b0; s_htrans = 2'b00; s_hwdata = d;
        waits = 0; err_pre = 1'b0;
        while (!s_hreadyout) begin
            err_pre = s_hresp;
            waits++;
            @(negedge clk);
        end
        err = s_hresp;
        rdat = s_hrdata;
        exp_dn++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w;
        logic [DW-1:0] r;
        logic e, ep;
        logic [DW-1:0] d1, d2;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 m_htrans", int'(m_htrans), 0);
        check("R1 hreadyout", int'(s_hreadyout), 1);
        check("R1 hresp", int'(s_hresp), 0);
        check("R1 wr_err_flag", int'(wr_err_flag), 0);

        // R9 IDLE, BUSY, unselected NONSEQ
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            check("R9 hreadyout", int'(s_hreadyout), 1);
            check("R9 hresp", int'(s_hresp), 0);
            s_hsel   = (k < 6);
            s_htrans = (k < 3) ? 2'b00 : ((k < 6) ? 2'b01 : 2'b10);
            s_hwrite = k[0];
        end
        @(negedge clk);
        s_hsel = 1'b0; s_htrans = 2'b00;
        idle(5);
        check("R9 no downstream transfer", dn_count, 0);

        for (int wc = 0; wc < 4; wc++) begin
            wait_cfg = wc;
            idle(4);
            for (int i = 0; i < 15; i++) begin
                d1 = DW'(wc * 4099 + i * 257 + 16'h1234);
                xfer(1'b1, AW'(i * 2), d1, w, r, e, ep);
                check("R2 write zero wait", w, 0);
                check("R2 write okay", int'(e), 0);
                exp_mem[i] = d1;
                xfer(1'b0, AW'(i * 2), '0, w, r, e, ep);
                check("R5 read after posted write waits", w, 5 + 2 * wc);
                check("R5 read returns posted data", int'(r), int'(exp_mem[i]));
            end
            idle(6);
            xfer(1'b0, AW'(6), '0, w, r, e, ep);
            check("R6 read waits", w, 3 + wc);
            check("R6 read data", int'(r), int'(exp_mem[3]));
            idle(3);
            xfer(1'b0, AW'(ERR_IDX * 2), '0, w, r, e, ep);
            check("R7 error read waits", w, 5 + wc);
            check("R7 first error cycle", int'(ep), 1);
            check("R7 final error cycle", int'(e), 1);
            check("R8 read error leaves flag", int'(wr_err_flag), 0);

            // R4 back-to-back writes
            idle(3);
            d1 = DW'(16'hA000 + wc);
            d2 = DW'(16'hB000 + wc);
            @(negedge clk);
            s_hsel = 1'b1; s_htrans = 2'b10; s_hwrite = 1'b1; s_haddr = AW'(2); s_hsize = 3'd1;
            @(negedge clk);
            check("R2 first pipelined write ready", int'(s_hreadyout), 1);
            s_haddr = AW'(4); s_hwdata = d1;
            @(negedge clk);
            s_hsel = 1'b0; s_htrans = 2'b00; s_hwdata = d2;
            w = 0;
            while (!s_hreadyout) begin w++; @(negedge clk); end
            check("R4 second write waits for drain", w, 3 + wc);
            exp_dn += 2;
            exp_mem[1] = d1;
            exp_mem[2] = d2;
            xfer(1'b0, AW'(2), '0, w, r, e, ep);
            check("R3 first replayed write", int'(r), int'(d1));
            xfer(1'b0, AW'(4), '0, w, r, e, ep);
            check("R3 second replayed write", int'(r), int'(d2));
            idle(6);
            check("R3 downstream transfer count", dn_count, exp_dn);
        end

        // R8 posted write error
        xfer(1'b1, AW'(ERR_IDX * 2), 16'hDEAD, w, r, e, ep);
        check("R8 errored write still zero wait", w, 0);
        check("R8 errored write okay upstream", int'(e), 0);
        idle(10);
        check("R8 flag set", int'(wr_err_flag), 1);
        xfer(1'b1, AW'(0), 16'h0F0F, w, r, e, ep);
        exp_mem[0] = 16'h0F0F;
        idle(10);
        check("R8 flag sticky", int'(wr_err_flag), 1);

        // R10 no combinational or single-flop path to m_htrans
        @(negedge clk);
        s_hsel = 1'b1; s_htrans = 2'b10; s_hwrite = 1'b0; s_haddr = AW'(0);
        #1;
        check("R10 same-cycle m_htrans", int'(m_htrans), 0);
        @(negedge clk);
        s_hsel = 1'b0; s_htrans = 2'b00;
        check("R10 next-cycle m_htrans", int'(m_htrans), 0);
        @(negedge clk);
        check("R10 launch cycle m_htrans", int'(m_htrans), 2);
        while (!s_hreadyout) @(negedge clk);
        check("R6 read data after launch", int'(s_hrdata), int'(exp_mem[0]));
        exp_dn++;
        idle(6);
        check("R3 final transfer count", dn_count, exp_dn);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule